// File: doc/BRIEF.md
# Multi-Register Block Load Sequencer

This block carries out a block-load operation. It copies a run of consecutive words into consecutive entries of a 16-entry general register file. A pulse on `start` latches three values: the first destination register, the effective word address and the current condition code. The condition code gives the number of words to move, and a value of zero means sixteen. Word k is fetched from address `start_addr + k` and written to register `(start_reg + k) mod 16`. Destination numbers wrap from 15 back to 0.

Each word is fetched through a valid/ready read request port. At most one read is outstanding at a time. The word arrives on a response port together with two fault flags, one for an access-protection violation and one for nonexistent memory. A word whose address is below 16 is not read from memory. It is read from the general register with that number.

A faulted response ends the operation with a one-cycle trap pulse, which reports the faulting address and the fault cause. Registers written before the fault keep their new values. A host port lets the surrounding pipeline write and read registers while the sequencer is idle.

Top module: `blk_load_seq`

## Requirements
- R1: The number of register writes made by an operation equals the condition code latched at start, and a code of 0 gives 16 writes.
- R2: Word k (k = 0 … count-1) is written to register (start_reg + k) mod 16, so register 15 is followed by register 0.
- R3: A word at address 16 or above is requested with `mem_req_addr` = start_addr + k. The request holds valid and address steady until ready is seen. No new request is made until the response arrives.
- R4: A word at address 0 to 15 is copied from the register with that number, and no memory request is made for it.
- R5: A response with `mem_rsp_prot` or `mem_rsp_nomem` set gives `trap` high for exactly one cycle, and `done` is not asserted. `trap_addr` equals the faulting word address. `trap_cause` bit 0 is the protection flag and bit 1 is the nonexistent flag. No register is written for that word or any later word, and registers written earlier keep their values.
- R6: `busy` is high from the cycle after an accepted start until the cycle in which `done` or `trap` rises. `done` is high for exactly one cycle, the cycle after the last register write.
- R7: While `busy` is high, `start` and `host_wr_en` are ignored.
- R8: With the sequencer idle, a host write stores `host_wr_data` into register `host_wr_sel`. `host_rd_data` shows register `host_rd_sel` one cycle after the select is applied.
- R9: After reset `busy`, `done`, `trap` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| start_reg | input | RW | First destination register |
| start_addr | input | AW | Effective word address of the first word |
| cond_code | input | RW | Condition code; word count, 0 means 16 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the last register write |
| trap | output | 1 | One-cycle pulse on a faulted read |
| trap_addr | output | AW | Address of the faulting word |
| trap_cause | output | 2 | Bit 0 protection, bit 1 nonexistent memory |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW | Read request word address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | DW | Read response word |
| mem_rsp_prot | input | 1 | Response faulted on access protection |
| mem_rsp_nomem | input | 1 | Response faulted on nonexistent memory |
| host_wr_en | input | 1 | Host register write enable (idle only) |
| host_wr_sel | input | RW | Host write register number |
| host_wr_data | input | DW | Host write data |
| host_rd_sel | input | RW | Host read register number |
| host_rd_data | output | DW | Registered host read data |

## Verification
Each result has a known latency, and the bench samples it there:
- A word from a register lands in the clock edge of the cycle in which it is selected.
- A memory word lands in the edge that captures its response.
- `done` or `trap` is visible in the cycle after that edge, and `busy` is visible in the cycle after the start edge.
- Host read data is due one edge after the select.

The bench drives inputs and samples outputs on the falling edge. It waits for `done` or `trap` and checks the pulse value in that same cycle. It checks that the pulse is gone one cycle later. Only after that does it compare every register through the host read port, one select per cycle.

// File: rtl/blk_load_pkg.sv
package blk_load_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  localparam int CAUSE_W = 2;

endpackage

// File: rtl/blr_regfile.sv
module blr_regfile #(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] asel,
  output logic [DW-1:0] adata,
  input  logic [RW-1:0] bsel,
  output logic [DW-1:0] bdata
);
  localparam int NREG = 1 << RW;

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[wsel] <= wdata;
    bdata <= mem[bsel];
  end

  assign adata = mem[asel];
endmodule

// File: rtl/blr_ctrl.sv
module blr_ctrl
  import blk_load_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [RW-1:0]      start_reg,
  input  logic [AW-1:0]      start_addr,
  input  logic [RW-1:0]      cond_code,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  input  logic               rsp_valid,
  input  logic               rsp_prot,
  input  logic               rsp_nomem,
  output logic [RW-1:0]      src_sel,
  output logic               rf_we,
  output logic [RW-1:0]      rf_wsel,
  output logic               wsrc_rf,
  output logic               busy,
  output logic               done,
  output logic               trap,
  output logic [AW-1:0]      trap_addr,
  output logic [CAUSE_W-1:0] trap_cause
);
  localparam int NREG = 1 << RW;
  localparam int KW   = RW + 1;

  seq_state_t     state;
  logic [RW-1:0]  dst;
  logic [AW-1:0]  waddr;
  logic [KW-1:0]  kcnt;
  logic [KW-1:0]  total;
  logic           low;
  logic           last;
  logic           fault;

  always_comb begin
    low           = (waddr < AW'(NREG));
    last          = (kcnt == total - KW'(1));
    fault         = rsp_prot | rsp_nomem;
    mem_req_valid = (state == ST_ISSUE) && !low;
    mem_req_addr  = waddr;
    src_sel       = waddr[RW-1:0];
    wsrc_rf       = (state == ST_ISSUE);
    rf_wsel       = dst;
    rf_we         = ((state == ST_ISSUE) && low) ||
                    ((state == ST_WAIT) && rsp_valid && !fault);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      dst        <= '0;
      waddr      <= '0;
      kcnt       <= '0;
      total      <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      trap       <= 1'b0;
      trap_addr  <= '0;
      trap_cause <= '0;
    end else begin
      done <= 1'b0;
      trap <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            dst   <= start_reg;
            waddr <= start_addr;
            kcnt  <= '0;
            total <= (cond_code == '0) ? KW'(NREG) : KW'(cond_code);
            busy  <= 1'b1;
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!low && mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid && fault) begin
            trap       <= 1'b1;
            trap_addr  <= waddr;
            trap_cause <= {rsp_nomem, rsp_prot};
            busy       <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (rf_we) begin
        if (last) begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end else begin
          kcnt  <= kcnt + KW'(1);
          dst   <= dst + RW'(1);
          waddr <= waddr + AW'(1);
          state <= ST_ISSUE;
        end
      end
    end
  end
endmodule

// File: rtl/blk_load_seq.sv
module blk_load_seq
  import blk_load_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [RW-1:0]      start_reg,
  input  logic [AW-1:0]      start_addr,
  input  logic [RW-1:0]      cond_code,
  output logic               busy,
  output logic               done,
  output logic               trap,
  output logic [AW-1:0]      trap_addr,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [DW-1:0]      mem_rsp_data,
  input  logic               mem_rsp_prot,
  input  logic               mem_rsp_nomem,
  input  logic               host_wr_en,
  input  logic [RW-1:0]      host_wr_sel,
  input  logic [DW-1:0]      host_wr_data,
  input  logic [RW-1:0]      host_rd_sel,
  output logic [DW-1:0]      host_rd_data
);
  logic          seq_we;
  logic [RW-1:0] seq_wsel;
  logic          wsrc_rf;
  logic [RW-1:0] src_sel;
  logic [DW-1:0] src_data;
  logic          rf_we;
  logic [RW-1:0] rf_wsel;
  logic [DW-1:0] rf_wdata;

  blr_ctrl #(.AW(AW), .RW(RW)) ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .start_reg     (start_reg),
    .start_addr    (start_addr),
    .cond_code     (cond_code),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (mem_rsp_valid),
    .rsp_prot      (mem_rsp_prot),
    .rsp_nomem     (mem_rsp_nomem),
    .src_sel       (src_sel),
    .rf_we         (seq_we),
    .rf_wsel       (seq_wsel),
    .wsrc_rf       (wsrc_rf),
    .busy          (busy),
    .done          (done),
    .trap          (trap),
    .trap_addr     (trap_addr),
    .trap_cause    (trap_cause)
  );

  always_comb begin
    if (seq_we) begin
      rf_we    = 1'b1;
      rf_wsel  = seq_wsel;
      rf_wdata = wsrc_rf ? src_data : mem_rsp_data;
    end else begin
      rf_we    = host_wr_en && !busy;
      rf_wsel  = host_wr_sel;
      rf_wdata = host_wr_data;
    end
  end

  blr_regfile #(.DW(DW), .RW(RW)) rf_i (
    .clk   (clk),
    .we    (rf_we),
    .wsel  (rf_wsel),
    .wdata (rf_wdata),
    .asel  (src_sel),
    .adata (src_data),
    .bsel  (host_rd_sel),
    .bdata (host_rd_data)
  );
endmodule

// File: rtl/blk_load_chk.sv
module blk_load_chk #(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [RW-1:0] cond_code,
  input logic          busy,
  input logic          done,
  input logic          trap,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          seq_we
);
  localparam int NREG = 1 << RW;
  localparam int KW   = RW + 1;

  logic [KW-1:0] wr_cnt;
  logic [KW-1:0] want;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt <= '0;
      want   <= '0;
    end else if (start && !busy) begin
      wr_cnt <= '0;
      want   <= (cond_code == '0) ? KW'(NREG) : KW'(cond_code);
    end else if (seq_we) begin
      wr_cnt <= wr_cnt + KW'(1);
    end
  end

  // R1: write count matches the latched condition code when done
  a_r1_write_count: assert property (@(posedge clk) disable iff (rst)
    done |-> (wr_cnt == want));

  // R3: a stalled request holds valid and address
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4: addresses below the register count never go to memory
  a_r4_no_low_req: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr >= AW'(NREG)));

  // R5: trap is a single-cycle pulse with no write and no done
  a_r5_trap_pulse: assert property (@(posedge clk) disable iff (rst)
    trap |=> !trap);
  a_r5_trap_quiet: assert property (@(posedge clk) disable iff (rst)
    trap |-> (!seq_we && !done));

  // R6: done is a single-cycle pulse and the block is idle with it
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    (done || trap) |-> !busy);
  a_r6_req_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);
endmodule

bind blk_load_seq blk_load_chk #(.AW(AW), .RW(RW)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .cond_code     (cond_code),
  .busy          (busy),
  .done          (done),
  .trap          (trap),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .seq_we        (seq_we)
);

// File: tb/blk_load_seq_tb_top.sv
`timescale 1ns/1ps
module blk_load_seq_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [RW-1:0] start_reg = '0;
  logic [AW-1:0] start_addr = '0;
  logic [RW-1:0] cond_code = '0;
  logic          busy, done, trap;
  logic [AW-1:0] trap_addr;
  logic [1:0]    trap_cause;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          mem_rsp_prot = 1'b0;
  logic          mem_rsp_nomem = 1'b0;
  logic          host_wr_en = 1'b0;
  logic [RW-1:0] host_wr_sel = '0;
  logic [DW-1:0] host_wr_data = '0;
  logic [RW-1:0] host_rd_sel = '0;
  logic [DW-1:0] host_rd_data;

  always #4 clk = ~clk;

  blk_load_seq #(.AW(AW), .DW(DW), .RW(RW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_reg(start_reg),
    .start_addr(start_addr), .cond_code(cond_code), .busy(busy),
    .done(done), .trap(trap), .trap_addr(trap_addr), .trap_cause(trap_cause),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_prot(mem_rsp_prot),
    .mem_rsp_nomem(mem_rsp_nomem), .host_wr_en(host_wr_en),
    .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
    .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int flt_addr = -1;
  int flt_kind = 0;
  int req_cnt = 0;
  int bad_req = 0;

  logic [DW-1:0] shadow [16];

  function automatic logic [DW-1:0] memf(input int a);
    return {a[15:0], ~a[15:0]} ^ 32'hC3A5_1E0F;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // memory responder: grants, then answers after 0..2 cycles
  bit pend = 0;
  int lat = 0;
  int acc_a = 0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_prot  = 1'b0;
    mem_rsp_nomem = 1'b0;
    if (rst) begin
      mem_req_ready = 1'b0;
      pend = 0;
    end else begin
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memf(acc_a);
          if (acc_a == flt_addr) begin
            mem_rsp_prot  = flt_kind[0];
            mem_rsp_nomem = flt_kind[1];
          end
          pend = 0;
        end else lat--;
      end
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        pend = 1;
        lat = $urandom_range(0, 2);
        req_cnt++;
      end else if (mem_req_valid && !pend) begin
        if (mem_req_addr != AW'(acc_a + 1) && req_cnt != 0 && mem_req_addr < 16) bad_req++;
        acc_a = int'(mem_req_addr);
        mem_req_ready = (($urandom % 4) != 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  task automatic host_write(input int sel, input logic [DW-1:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_sel = RW'(sel); host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic compare_all(input int skip_tag);
    for (int i = 0; i < 16; i++) begin
      host_rd_sel = RW'(i);
      @(negedge clk);
      if (i == skip_tag)
        check(host_rd_data == shadow[i], "R7", $sformatf("busy host write reg %0d", i),
              host_rd_data, shadow[i]);
      else
        check(host_rd_data == shadow[i], "R2", $sformatf("reg %0d", i),
              host_rd_data, shadow[i]);
    end
  endtask

  task automatic run_op(input int r, input int ea, input int cc,
                        input int fa, input int fk, input bit inject);
    int cnt, exp_req, exp_ta, wtag;
    bit exp_trap, seen;
    logic [DW-1:0] pre [16];
    logic [DW-1:0] junk;
    // preload registers with fresh values
    for (int i = 0; i < 16; i++) begin
      pre[i] = $urandom;
      host_write(i, pre[i]);
      shadow[i] = pre[i];
    end
    flt_addr = fa; flt_kind = fk;
    cnt = (cc == 0) ? 16 : cc;
    exp_req = 0; exp_trap = 0; exp_ta = 0;
    for (int k = 0; k < cnt; k++) begin
      int wa;
      wa = ea + k;
      if (wa >= 16) exp_req++;
      if (wa >= 16 && wa == fa && fk != 0) begin
        exp_trap = 1; exp_ta = wa;
        break;
      end
      shadow[(r + k) % 16] = (wa < 16) ? shadow[wa] : memf(wa);
    end
    wtag = -1;
    junk = 32'hDEAD_0000 ^ $urandom;
    req_cnt = 0;
    @(negedge clk);
    start = 1'b1; start_reg = RW'(r); start_addr = AW'(ea); cond_code = RW'(cc);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6", "busy after start", busy, 1);
    seen = 0;
    for (int t = 0; t < 400; t++) begin
      if (done || trap) begin seen = 1; break; end
      if (inject && t == 2 && cnt < 16) begin
        wtag = (r + cnt) % 16;
        start = 1'b1; start_reg = RW'(wtag); start_addr = AW'(ea + 40);
        cond_code = RW'(cc + 1);
        host_wr_en = 1'b1; host_wr_sel = RW'(wtag); host_wr_data = junk;
      end
      @(negedge clk);
      start = 1'b0; host_wr_en = 1'b0;
    end
    check(seen, "R6", "operation completes", seen, 1);
    check(done == !exp_trap, "R6", "done pulse", done, !exp_trap);
    check(trap == exp_trap, "R5", "trap pulse", trap, exp_trap);
    check(busy == 1'b0, "R6", "busy low at finish", busy, 0);
    if (exp_trap) begin
      check(int'(trap_addr) == exp_ta, "R5", "trap address", trap_addr, exp_ta);
      check(int'(trap_cause) == fk, "R5", "trap cause", trap_cause, fk);
    end
    check(req_cnt == exp_req, "R3", "memory request count", req_cnt, exp_req);
    check(bad_req == 0, "R4", "low address requested", bad_req, 0);
    @(negedge clk);
    check(!done && !trap, "R6", "pulse lasts one cycle", {done, trap}, 0);
    compare_all(wtag);
  endtask

  function automatic bit overlaps(input int r, input int ea, input int cnt);
    for (int k = 0; k < cnt; k++)
      for (int j = 0; j < cnt; j++)
        if (ea + j < 16 && ((r + k) % 16) == ea + j) return 1;
    return 0;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!busy && !done && !trap && !mem_req_valid, "R9", "reset outputs",
          {busy, done, trap, mem_req_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R8: host write then registered read
    host_write(9, 32'h1357_9BDF);
    host_rd_sel = 4'd9;
    @(negedge clk);
    check(host_rd_data == 32'h1357_9BDF, "R8", "host read back", host_rd_data, 32'h1357_9BDF);

    // directed corners
    run_op(5, 100, 0, -1, 0, 0);   // R1: code 0 moves 16 words, wraps
    run_op(15, 40, 1, -1, 0, 0);   // R1: single word into reg 15
    run_op(14, 60, 5, -1, 0, 1);   // R2 wrap 14,15,0,1,2; R7 injection
    run_op(0, 12, 8, -1, 0, 0);    // R4: mix of register and memory sources
    run_op(8, 0, 8, -1, 0, 1);     // R4: all from registers; R7
    run_op(2, 50, 6, 50, 1, 0);    // R5: protection fault on first word
    run_op(3, 70, 9, 74, 2, 0);    // R5: nonexistent fault mid-run
    run_op(12, 200, 0, 215, 3, 0); // R5: both flags on last word

    for (int n = 0; n < 40; n++) begin
      int r, ea, cc, fa, fk, cnt;
      r = $urandom_range(0, 15);
      cc = $urandom_range(0, 15);
      cnt = (cc == 0) ? 16 : cc;
      ea = (($urandom % 5) == 0) ? $urandom_range(0, 15) : $urandom_range(16, 900);
      if (overlaps(r, ea, cnt)) ea = ea + 16;
      fa = -1; fk = 0;
      if (($urandom % 4) == 0) begin
        fa = ea + $urandom_range(0, cnt - 1);
        fk = $urandom_range(1, 3);
      end
      run_op(r, ea, cc, fa, fk, ($urandom % 2) == 1);
    end
    finish_run();
  end
endmodule